// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block produces the periodic interrupt event of a PC-style real-time clock. A free-running enable strobe at 32.768 kHz drives a divider. A four-bit rate code and a periodic-enable bit select the division ratio and switch the divider on or off. Each time the divider expires, the block emits a one-cycle event. In the same cycle it emits a flag-set mask that the status register ORs into its interrupt-request and periodic flags.

The register decode around the block supplies the rate code, the enable bit and a strobe. That strobe pulses once for every write to either control register, and each write restarts the divider. When the effective rate changes, the divider also starts a fresh period. The generator stays silent while the code is zero or the enable is clear.

Top module: `rtc_periodic_gen`

## Requirements
- R1: For rate codes 3 to 15, events repeat every 2^(code-1) timebase ticks. Code 3 gives 4 ticks and code 15 gives 16384 ticks.
- R2: Rate code 1 gives the same period as code 8 (128 ticks), and code 2 the same as code 9 (256 ticks).
- R3: While the rate code is 0 or the periodic-enable input is low, no event and no flag bit is ever asserted.
- R4: Each event lasts exactly one clock cycle. In that cycle flag_set equals 8'hC0: bit 7 is the interrupt-request flag and bit 6 is the periodic flag. In every other cycle flag_set is zero.
- R5: A change of the effective rate code clears the divider. Inputs change before clock edge E0. With a tick in every cycle, the first event is visible in the cycle after edge E0+P, where P is the new period.
- R6: A pulse on cfg_wr restarts the divider even when the code and enable keep their values. The first event then follows the same timing as in R5.
- R7: Dropping the periodic enable for one cycle and raising it again restarts the divider. The first event then appears one cycle later than in R5.
- R8: The divider advances only in cycles where tick_32k is high. With a tick in every second cycle, the event interval is 2·P clock cycles.
- R9: While rst is high and in the first cycle after it, periodic_evt is low and flag_set is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | One-cycle enable at the 32.768 kHz timebase rate |
| rate_sel | input | 4 | Rate code taken from the low nibble of control register A |
| pie_en | input | 1 | Periodic-interrupt enable bit from control register B |
| cfg_wr | input | 1 | Strobe that pulses once for every write to either control register |
| periodic_evt | output | 1 | One-cycle periodic expiry event |
| flag_set | output | 8 | Mask to OR into the status register; 8'hC0 during an event |

## Verification
The assertions take the rate code as a whole nibble that holds steady between the writes that change it. They also rely on the folding of codes 1 and 2, which keeps every active period at four ticks or more. That minimum is what lets the one-cycle-pulse property hold for any tick pattern. The stimulus changes the code, the enable and the strobe only at falling clock edges, and only one such change is in flight at a time. The sweep lets each period run to at least two events before the next change. Tick density has only two patterns, every cycle or every second cycle, so the expected intervals remain exact multiples of the period.

// File: rtl/rtc_pgen_pkg.sv
package rtc_pgen_pkg;

  // Status-flag positions decoded by the status register next door.
  localparam int unsigned IRQ_FLAG_BIT = 7;
  localparam int unsigned PER_FLAG_BIT = 6;

  // Low codes that are folded upward, and the amount added to them.
  localparam int unsigned FOLD_LIMIT = 2;
  localparam int unsigned FOLD_ADD   = 7;

  typedef enum logic [1:0] {
    DIV_IDLE    = 2'd0,
    DIV_RESTART = 2'd1,
    DIV_COUNT   = 2'd2
  } div_mode_e;

endpackage

// File: rtl/rtc_pgen_decode.sv
module rtc_pgen_decode
  import rtc_pgen_pkg::*;
#(
  parameter int unsigned RATE_W = 4,
  parameter int unsigned CNT_W  = (1 << RATE_W) - 2
) (
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              pie_en,
  output logic [RATE_W-1:0] eff_code,
  output logic              active,
  output logic [CNT_W-1:0]  last_cnt
);

  localparam logic [RATE_W-1:0] FOLD_LIM_V = RATE_W'(FOLD_LIMIT);
  localparam logic [RATE_W-1:0] FOLD_ADD_V = RATE_W'(FOLD_ADD);

  logic [RATE_W-1:0] shamt;
  logic [CNT_W:0]    period;

  always_comb begin
    if (rate_sel != '0 && rate_sel <= FOLD_LIM_V)
      eff_code = rate_sel + FOLD_ADD_V;
    else
      eff_code = rate_sel;
  end

  always_comb begin
    active = pie_en && (eff_code != '0);
    shamt  = (eff_code == '0) ? '0 : eff_code - RATE_W'(1);
    period = (CNT_W + 1)'(1) << shamt;
    last_cnt = CNT_W'(period - (CNT_W + 1)'(1));
  end

  // R2: folding leaves no active code below 3.
  always_comb begin
    if (active)
      p_fold_floor_r2: assert (eff_code > FOLD_LIM_V);
  end

endmodule

// File: rtl/rtc_pgen_divider.sv
module rtc_pgen_divider
  import rtc_pgen_pkg::*;
#(
  parameter int unsigned RATE_W = 4,
  parameter int unsigned CNT_W  = (1 << RATE_W) - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cfg_wr,
  input  logic [RATE_W-1:0] eff_code,
  input  logic              active,
  input  logic [CNT_W-1:0]  last_cnt,
  output logic              expire
);

  logic [CNT_W-1:0]  cnt_q;
  logic [RATE_W-1:0] code_q;
  logic              act_q;
  logic              restart;
  div_mode_e         mode;

  always_comb begin
    restart = cfg_wr || (eff_code != code_q) || (active != act_q);
    if (restart)
      mode = DIV_RESTART;
    else if (active && tick)
      mode = DIV_COUNT;
    else
      mode = DIV_IDLE;
    expire = (mode == DIV_COUNT) && (cnt_q == last_cnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      code_q <= '0;
      act_q  <= 1'b0;
    end else begin
      code_q <= eff_code;
      act_q  <= active;
      case (mode)
        DIV_RESTART: cnt_q <= '0;
        DIV_COUNT:   cnt_q <= (cnt_q == last_cnt) ? '0 : cnt_q + CNT_W'(1);
        default:     cnt_q <= cnt_q;
      endcase
    end
  end

  // R5: a restart leaves the divider at zero.
  p_restart_clear_r5: assert property (@(posedge clk) disable iff (rst)
    $past(restart) |-> (cnt_q == '0));

  // R1: the counter never runs past the terminal value of a steady rate.
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    (!restart && active) |-> (cnt_q <= last_cnt));

  // R8: without a tick the count holds.
  p_tick_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/rtc_pgen_flags.sv
module rtc_pgen_flags
  import rtc_pgen_pkg::*;
#(
  parameter int unsigned FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  output logic              evt,
  output logic [FLAG_W-1:0] flags
);

  logic [FLAG_W-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    set_mask[IRQ_FLAG_BIT] = 1'b1;
    set_mask[PER_FLAG_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt   <= 1'b0;
      flags <= '0;
    end else begin
      evt   <= fire;
      flags <= fire ? set_mask : '0;
    end
  end

  // R4: mask and event agree.
  p_mask_match_r4: assert property (@(posedge clk) disable iff (rst)
    (flags != '0) |-> (evt && flags == set_mask));

  // R4: one cycle wide.
  p_single_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    evt |=> !evt);

endmodule

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen
  import rtc_pgen_pkg::*;
#(
  parameter int unsigned RATE_W = 4,
  parameter int unsigned FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_32k,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              pie_en,
  input  logic              cfg_wr,
  output logic              periodic_evt,
  output logic [FLAG_W-1:0] flag_set
);

  localparam int unsigned MAX_CODE = (1 << RATE_W) - 1;
  localparam int unsigned CNT_W    = MAX_CODE - 1;

  logic [RATE_W-1:0] eff_code;
  logic              active;
  logic [CNT_W-1:0]  last_cnt;
  logic              expire;

  rtc_pgen_decode #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_decode (
    .rate_sel (rate_sel),
    .pie_en   (pie_en),
    .eff_code (eff_code),
    .active   (active),
    .last_cnt (last_cnt)
  );

  rtc_pgen_divider #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_32k),
    .cfg_wr   (cfg_wr),
    .eff_code (eff_code),
    .active   (active),
    .last_cnt (last_cnt),
    .expire   (expire)
  );

  rtc_pgen_flags #(.FLAG_W(FLAG_W)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .fire  (expire),
    .evt   (periodic_evt),
    .flags (flag_set)
  );

  // R3: an event only follows a cycle in which the generator was enabled.
  p_quiet_off_r3: assert property (@(posedge clk) disable iff (rst)
    periodic_evt |-> $past(active));

  // R9: the output register is clear right after reset.
  p_reset_clear_r9: assert property (@(posedge clk)
    $past(rst) |-> (!periodic_evt && flag_set == '0));

endmodule

// File: tb/tb_rtc_periodic_gen.sv
module tb_rtc_periodic_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_32k = 1'b1;
  logic [3:0] rate_sel = 4'd0;
  logic       pie_en = 1'b0;
  logic       cfg_wr = 1'b0;
  logic       periodic_evt;
  logic [7:0] flag_set;
  logic       slow_tick = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(negedge clk) tick_32k <= slow_tick ? ~tick_32k : 1'b1;

  rtc_periodic_gen dut (
    .clk(clk), .rst(rst), .tick_32k(tick_32k), .rate_sel(rate_sel),
    .pie_en(pie_en), .cfg_wr(cfg_wr), .periodic_evt(periodic_evt),
    .flag_set(flag_set)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count falling edges until an event is seen; the limit stops a hung wait.
  task automatic wait_evt(input int limit, output int n);
    n = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      n++;
      if (periodic_evt) return;
    end
    n = -1;
  endtask

  // At the negedge of an event: mask, then one-cycle width.
  task automatic chk_pulse_shape();
    chk(flag_set == 8'hC0, "R4 mask", flag_set, 8'hC0);
    @(negedge clk);
    chk(!periodic_evt && flag_set == 8'h00, "R4 width", {periodic_evt, flag_set}, 0);
  endtask

  task automatic quiet_window(input string req, input int len);
    int hits;
    hits = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (periodic_evt || flag_set != 8'h00) hits++;
    end
    chk(hits == 0, req, hits, 0);
  endtask

  function automatic int period_of(input int code);
    int c;
    c = (code == 1 || code == 2) ? code + 7 : code;
    return 1 << (c - 1);
  endfunction

  initial begin
    int n;
    int p;
    // R9: outputs clear during reset
    repeat (3) @(negedge clk);
    chk(!periodic_evt && flag_set == 8'h00, "R9 during reset", {periodic_evt, flag_set}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!periodic_evt && flag_set == 8'h00, "R9 after reset", {periodic_evt, flag_set}, 0);

    // R3: code zero with enable set
    pie_en = 1'b1; rate_sel = 4'd0;
    quiet_window("R3 code zero", 300);
    // R3: enable clear with a valid code
    pie_en = 1'b0; rate_sel = 4'd3;
    quiet_window("R3 enable clear", 300);

    // R1 / R2 / R5: sweep every code, first event and interval
    for (int code = 1; code <= 15; code++) begin
      @(negedge clk);
      pie_en = 1'b1;
      rate_sel = code[3:0];
      p = period_of(code);
      wait_evt(p + 4, n);
      chk(n == p + 1, (code <= 2) ? "R2/R5 first event" : "R5 first event", n, p + 1);
      chk_pulse_shape();
      wait_evt(p + 4, n);
      chk(n == p - 1, (code <= 2) ? "R2 interval" : "R1 interval", n + 1, p);
      if (code == 1 || code == 2)
        chk(p == period_of(code + 7), "R2 fold", p, period_of(code + 7));
    end

    // R6: a write strobe with unchanged values restarts the divider
    @(negedge clk);
    rate_sel = 4'd6;
    wait_evt(40, n);
    repeat (10) @(negedge clk);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    wait_evt(40, n);
    chk(n == 32, "R6 restart", n + 1, 33);

    // R7: enable dropped for one cycle
    wait_evt(40, n);
    repeat (5) @(negedge clk);
    pie_en = 1'b0;
    @(negedge clk);
    chk(!periodic_evt, "R7 off cycle", periodic_evt, 0);
    pie_en = 1'b1;
    wait_evt(40, n);
    chk(n == 33, "R7 restart", n + 1, 34);

    // R8: tick every second cycle doubles the interval in clocks
    @(negedge clk);
    slow_tick = 1'b1;
    rate_sel = 4'd4;
    wait_evt(60, n);
    wait_evt(60, n);
    chk(n == 16, "R8 half-rate ticks", n, 16);
    wait_evt(60, n);
    chk(n == 16, "R8 half-rate repeat", n, 16);

    // R3: disabling mid-period stops everything
    slow_tick = 1'b0;
    pie_en = 1'b0;
    quiet_window("R3 stopped", 200);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule